// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command front end of a parallel NOR flash. It is a synthesizable model built over a small on-chip array. A host writes bus cycles (address, data, write strobe) to the block. A multi-write command decoder turns those cycles into operations:

- an unlock-prefixed byte program;
- a six-write chip erase;
- suspend and resume of a running program;
- entry to and exit from an identification mode.

Program and erase run as timed internal operations. During such an operation a read returns status bits in place of array data, and the ready output is held low.

When idle, reads return array contents. A program only clears bits: the stored word becomes the old word AND the new word. Only erase brings bits back to 1. A suspended program frees the array for reads and for identification-code reads. Leaving identification mode returns to the suspended state, and the program can then be resumed.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, ready is 1 and the block is in read mode.
- R2: Four writes start a program: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the target address and data. Ready goes low in the cycle after the fourth write and stays low for PROG_CYC cycles.
- R3: A program stores old AND new data at the target, so a 0 bit never returns to 1 through a program.
- R4: Six writes start a chip erase: 0xAA at 0x555, 0x55 at 0x2AA, 0x80 at 0x555, 0xAA at 0x555, 0x55 at 0x2AA, 0x10 at 0x555. Ready is low for 2^AW cycles, one per word, and every word then reads 0xFF.
- R5: While busy, a read returns a status word with all bits 0 except these two:
  - bit 7 is the complement of bit 7 of the data being written (0 during erase);
  - bit 6 starts at 0 and inverts on every read.
- R6: While a program runs, every write except 0xB0 is ignored: the operation neither aborts nor changes its length.
- R7: Writing 0xB0 during a program suspends it. Ready is 1 in the next cycle, and the remaining count is kept.
- R8: In suspend, writing 0x30 resumes the program. Ready is low in the next cycle. A further 0x30 while running is ignored, and a later 0xB0 suspends again.
- R9: In suspend, reads of other addresses return array data.
- R10: The unlock pair followed by 0x90 at 0x555 enters identification mode. In that mode, reads return a value chosen by address bits [1:0]: 0x5A for 0, 0xC3 for 1, 0x00 otherwise. Writing 0xF0 returns to read mode.
- R11: Identification mode can be entered from suspend, and 0xF0 then returns to suspend. Program and erase commands are not accepted in suspend.
- R12: A write that breaks a command sequence returns the decoder to its base mode (read, or suspend). Commands that follow the broken sequence are not taken up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe, one bus write per cycle it is high |
| re | input | 1 | Read strobe; rdata is valid the cycle after |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data |
| rdata | output | DW | Read data: array word, identification code or status |
| ready | output | 1 | High unless a program or erase is running unsuspended |

## Verification
The checker watches the decoder state on every cycle and covers these control rules:
- ready comes up after reset;
- a program starts on the write that follows the program setup command;
- busy-time writes other than suspend are dropped;
- suspend frees the bus at once;
- resume makes the block busy again;
- leaving identification mode while suspended returns to suspend;
- ready is never low while a program is held in suspend.

Some behaviour can only be shown by the bench scenarios. These are the AND result of a program, the erased array contents, the exact busy lengths after one or two suspensions, the bit-7 and bit-6 patterns of the status word, the identification codes, and the dropping of commands after a broken unlock sequence.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_PGM_SETUP,
        ST_ERS_SETUP,
        ST_ERS_UNL1,
        ST_ERS_UNL2,
        ST_PGM_BUSY,
        ST_ERS_BUSY,
        ST_SUSP,
        ST_AUTOSEL
    } fcd_state_e;

    typedef enum logic [1:0] {
        RD_ARRAY,
        RD_IDENT,
        RD_STATUS
    } rd_src_e;

    typedef struct packed {
        logic [10:0] low_addr;
        logic [7:0]  code;
    } bus_cmd_t;

    localparam logic [10:0] A_KEY1 = 11'h555;
    localparam logic [10:0] A_KEY2 = 11'h2AA;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PGM     = 8'hA0;
    localparam logic [7:0] CMD_ERS_PRE = 8'h80;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_SUSP    = 8'hB0;
    localparam logic [7:0] CMD_RESUME  = 8'h30;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_RESET   = 8'hF0;

    localparam logic [7:0] ID_MAKER  = 8'h5A;
    localparam logic [7:0] ID_DEVICE = 8'hC3;

    function automatic logic is_cmd(bus_cmd_t c, logic [10:0] a, logic [7:0] d);
        return (c.low_addr == a) && (c.code == d);
    endfunction

    function automatic logic [7:0] ident_code(logic [1:0] sel);
        case (sel)
            2'd0:    return ID_MAKER;
            2'd1:    return ID_DEVICE;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/fcd_array.sv
module fcd_array
    import flash_cmd_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ers_en,
    input  logic [AW-1:0] ers_addr,
    input  logic          pgm_commit,
    input  logic [AW-1:0] pgm_addr,
    input  logic [DW-1:0] pgm_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (ers_en) begin
            mem[ers_addr] <= '1;
        end else if (pgm_commit) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
        if (rd_en) begin
            rd_q <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int PROG_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output fcd_state_e    st,
    output logic          susp,
    output logic          cnt_zero,
    output logic          pgm_commit,
    output logic [AW-1:0] pgm_addr,
    output logic [DW-1:0] pgm_data,
    output logic          ers_en,
    output logic [AW-1:0] ers_addr
);
    localparam int CW = $clog2(PROG_CYC + 1);

    logic [CW-1:0] cnt;
    logic [AW-1:0] ptr;
    bus_cmd_t      c;
    fcd_state_e    base;

    assign c          = '{low_addr: addr[10:0], code: wdata[7:0]};
    assign base       = susp ? ST_SUSP : ST_READ;
    assign cnt_zero   = (cnt == '0);
    assign pgm_commit = (st == ST_PGM_BUSY) && cnt_zero;
    assign ers_en     = (st == ST_ERS_BUSY);
    assign ers_addr   = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_READ;
            susp     <= 1'b0;
            cnt      <= '0;
            ptr      <= '0;
            pgm_addr <= '0;
            pgm_data <= '0;
        end else begin
            case (st)
                ST_READ: begin
                    if (we && is_cmd(c, A_KEY1, CMD_KEY1)) st <= ST_UNL1;
                end
                ST_UNL1: begin
                    if (we) st <= is_cmd(c, A_KEY2, CMD_KEY2) ? ST_UNL2 : base;
                end
                ST_UNL2: begin
                    if (we) begin
                        if (!susp && is_cmd(c, A_KEY1, CMD_PGM))          st <= ST_PGM_SETUP;
                        else if (!susp && is_cmd(c, A_KEY1, CMD_ERS_PRE)) st <= ST_ERS_SETUP;
                        else if (is_cmd(c, A_KEY1, CMD_IDENT))            st <= ST_AUTOSEL;
                        else                                              st <= base;
                    end
                end
                ST_PGM_SETUP: begin
                    if (we) begin
                        pgm_addr <= addr;
                        pgm_data <= wdata;
                        cnt      <= CW'(PROG_CYC - 1);
                        st       <= ST_PGM_BUSY;
                    end
                end
                ST_ERS_SETUP: begin
                    if (we) st <= is_cmd(c, A_KEY1, CMD_KEY1) ? ST_ERS_UNL1 : ST_READ;
                end
                ST_ERS_UNL1: begin
                    if (we) st <= is_cmd(c, A_KEY2, CMD_KEY2) ? ST_ERS_UNL2 : ST_READ;
                end
                ST_ERS_UNL2: begin
                    if (we) begin
                        ptr <= '0;
                        st  <= is_cmd(c, A_KEY1, CMD_CHIP) ? ST_ERS_BUSY : ST_READ;
                    end
                end
                ST_PGM_BUSY: begin
                    if (cnt_zero) begin
                        st <= ST_READ;
                    end else if (we && c.code == CMD_SUSP) begin
                        st   <= ST_SUSP;
                        susp <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ERS_BUSY: begin
                    if (&ptr) st  <= ST_READ;
                    else      ptr <= ptr + 1'b1;
                end
                ST_SUSP: begin
                    if (we) begin
                        if (c.code == CMD_RESUME) begin
                            st   <= ST_PGM_BUSY;
                            susp <= 1'b0;
                        end else if (is_cmd(c, A_KEY1, CMD_KEY1)) begin
                            st <= ST_UNL1;
                        end
                    end
                end
                ST_AUTOSEL: begin
                    if (we && c.code == CMD_RESET) st <= base;
                end
                default: st <= ST_READ;
            endcase
        end
    end

endmodule

// File: rtl/fcd_readout.sv
module fcd_readout
    import flash_cmd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          re,
    input  logic [1:0]    id_sel,
    input  fcd_state_e    st,
    input  logic          pgm_d7,
    input  logic [DW-1:0] arr_q,
    output logic [DW-1:0] rdata
);
    rd_src_e       src_q;
    logic [DW-1:0] val_q;
    logic [DW-1:0] stat_w;
    logic          tgl;
    logic          busy;

    assign busy = (st == ST_PGM_BUSY) || (st == ST_ERS_BUSY);

    always_comb begin
        stat_w    = '0;
        stat_w[7] = (st == ST_PGM_BUSY) ? ~pgm_d7 : 1'b0;
        stat_w[6] = tgl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= RD_ARRAY;
            val_q <= '0;
            tgl   <= 1'b0;
        end else begin
            if (!busy)   tgl <= 1'b0;
            else if (re) tgl <= ~tgl;
            if (re) begin
                if (busy) begin
                    src_q <= RD_STATUS;
                    val_q <= stat_w;
                end else if (st == ST_AUTOSEL) begin
                    src_q <= RD_IDENT;
                    val_q <= DW'(ident_code(id_sel));
                end else begin
                    src_q <= RD_ARRAY;
                end
            end
        end
    end

    assign rdata = (src_q == RD_ARRAY) ? arr_q : val_q;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW       = 11,
    parameter int DW       = 8,
    parameter int PROG_CYC = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          ready
);
    fcd_state_e    st;
    logic          susp;
    logic          cnt_zero;
    logic          pgm_commit;
    logic [AW-1:0] pgm_addr;
    logic [DW-1:0] pgm_data;
    logic          ers_en;
    logic [AW-1:0] ers_addr;
    logic [DW-1:0] arr_q;

    fcd_seq #(.AW(AW), .DW(DW), .PROG_CYC(PROG_CYC)) i_seq (
        .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
        .st(st), .susp(susp), .cnt_zero(cnt_zero),
        .pgm_commit(pgm_commit), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .ers_en(ers_en), .ers_addr(ers_addr)
    );

    fcd_array #(.AW(AW), .DW(DW)) i_array (
        .clk(clk), .ers_en(ers_en), .ers_addr(ers_addr),
        .pgm_commit(pgm_commit), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .rd_en(re), .rd_addr(addr), .rd_q(arr_q)
    );

    fcd_readout #(.DW(DW)) i_readout (
        .clk(clk), .rst(rst), .re(re), .id_sel(addr[1:0]), .st(st),
        .pgm_d7(pgm_data[7]), .arr_q(arr_q), .rdata(rdata)
    );

    assign ready = !((st == ST_PGM_BUSY) || (st == ST_ERS_BUSY));

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       we,
    input logic [7:0] wdata,
    input logic       ready,
    input fcd_state_e st,
    input logic       susp,
    input logic       cnt_zero
);
    AST_RESET_READY: assert property (@(posedge clk) rst |=> ready); // R1

    AST_PGM_START: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PGM_SETUP && we) |=> !ready); // R2

    AST_BUSY_DROPS_WRITES: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PGM_BUSY && !cnt_zero && we && wdata != CMD_SUSP) |=> (st == ST_PGM_BUSY)); // R6

    AST_SUSPEND_FREES: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PGM_BUSY && !cnt_zero && we && wdata == CMD_SUSP) |=> (ready && st == ST_SUSP)); // R7

    AST_HELD_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        susp |-> ready); // R7

    AST_RESUME_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SUSP && we && wdata == CMD_RESUME) |=> (!ready && !susp)); // R8

    AST_IDENT_TO_SUSP: assert property (@(posedge clk) disable iff (rst)
        (st == ST_AUTOSEL && susp && we && wdata == CMD_RESET) |=> (st == ST_SUSP)); // R11

endmodule

bind flash_cmd_decoder fcd_checker i_chk (
    .clk(clk), .rst(rst), .we(we), .wdata(wdata[7:0]), .ready(ready),
    .st(st), .susp(susp), .cnt_zero(cnt_zero)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int P     = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          we = 1'b0;
    logic          re = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          ready;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .DW(DW), .PROG_CYC(P)) i_flash_cmd_decoder (
        .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        re = 1'b1; addr = a;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic unlock();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    task automatic start_pgm(input logic [AW-1:0] a, input logic [DW-1:0] d);
        unlock();
        wr(11'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic t_erase();
        logic [DW-1:0] d;
        int n;
        unlock(); wr(11'h555, 8'h80);
        unlock(); wr(11'h555, 8'h10);
        chk(ready == 1'b0, "R4 busy after erase cmd", ready, 0);
        rd(11'h010, d); chk(d == 8'h00, "R5 erase status first", d, 8'h00);
        rd(11'h010, d); chk(d == 8'h40, "R5 erase status toggled", d, 8'h40);
        wait_ready(n);
        chk(n == DEPTH - 2, "R4 erase length", n, DEPTH - 2);
        rd(11'h000, d); chk(d == 8'hFF, "R4 word 0 erased", d, 8'hFF);
        rd(11'h7FF, d); chk(d == 8'hFF, "R4 last word erased", d, 8'hFF);
    endtask

    task automatic t_program();
        logic [DW-1:0] d;
        int n;
        start_pgm(11'h100, 8'h3C);
        chk(ready == 1'b0, "R2 busy after data write", ready, 0);
        rd(11'h100, d); chk(d == 8'h80, "R5 status bit7 complement", d, 8'h80);
        rd(11'h100, d); chk(d == 8'hC0, "R5 status bit6 toggles", d, 8'hC0);
        wait_ready(n);
        chk(n == P - 2, "R2 program length", n, P - 2);
        rd(11'h100, d); chk(d == 8'h3C, "R2 programmed data", d, 8'h3C);
    endtask

    task automatic t_and();
        logic [DW-1:0] d;
        int n;
        start_pgm(11'h100, 8'hF5);
        wait_ready(n);
        rd(11'h100, d); chk(d == 8'h34, "R3 old AND new", d, 8'h34);
        start_pgm(11'h101, 8'h80);
        rd(11'h101, d); chk(d == 8'h00, "R5 bit7 set gives status 0", d, 8'h00);
        wait_ready(n);
        rd(11'h101, d); chk(d == 8'h80, "R3 fresh word", d, 8'h80);
    endtask

    task automatic t_ignore();
        logic [DW-1:0] d;
        int n;
        start_pgm(11'h200, 8'h0F);
        wr(11'h555, 8'hF0);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        chk(ready == 1'b0, "R6 still busy", ready, 0);
        wait_ready(n);
        chk(n == P - 3, "R6 length unchanged", n, P - 3);
        rd(11'h200, d); chk(d == 8'h0F, "R6 data committed", d, 8'h0F);
        start_pgm(11'h201, 8'h11);
        wait_ready(n);
        rd(11'h201, d); chk(d == 8'h11, "R6 no stale sequence", d, 8'h11);
    endtask

    task automatic t_suspend();
        logic [DW-1:0] d;
        int n;
        start_pgm(11'h300, 8'h5A);
        repeat (5) @(negedge clk);
        wr(11'h000, 8'hB0);
        chk(ready == 1'b1, "R7 ready after suspend", ready, 1);
        rd(11'h100, d); chk(d == 8'h34, "R9 array read in suspend", d, 8'h34);
        wr(11'h000, 8'h30);
        chk(ready == 1'b0, "R8 busy after resume", ready, 0);
        wr(11'h000, 8'h30);
        chk(ready == 1'b0, "R8 second resume ignored", ready, 0);
        wr(11'h000, 8'hB0);
        chk(ready == 1'b1, "R8 later suspend accepted", ready, 1);
        wr(11'h000, 8'h30);
        wait_ready(n);
        chk(n == P - 6, "R8 remaining length", n, P - 6);
        rd(11'h300, d); chk(d == 8'h5A, "R8 resumed data", d, 8'h5A);
    endtask

    task automatic t_ident();
        logic [DW-1:0] d;
        unlock(); wr(11'h555, 8'h90);
        rd(11'h000, d); chk(d == 8'h5A, "R10 maker code", d, 8'h5A);
        rd(11'h001, d); chk(d == 8'hC3, "R10 device code", d, 8'hC3);
        rd(11'h006, d); chk(d == 8'h00, "R10 other offset", d, 8'h00);
        wr(11'h000, 8'hF0);
        rd(11'h100, d); chk(d == 8'h34, "R10 exit to array", d, 8'h34);
    endtask

    task automatic t_ident_susp();
        logic [DW-1:0] d;
        int n;
        start_pgm(11'h400, 8'h3C);
        wr(11'h000, 8'hB0);
        start_pgm(11'h500, 8'h00);
        chk(ready == 1'b1, "R11 program refused in suspend", ready, 1);
        unlock(); wr(11'h555, 8'h90);
        rd(11'h401, d); chk(d == 8'hC3, "R11 ident in suspend", d, 8'hC3);
        wr(11'h000, 8'hF0);
        rd(11'h100, d); chk(d == 8'h34, "R11 back to suspend reads", d, 8'h34);
        wr(11'h000, 8'h30);
        chk(ready == 1'b0, "R11 resume after ident", ready, 0);
        wait_ready(n);
        chk(n == P, "R11 full remaining length", n, P);
        rd(11'h400, d); chk(d == 8'h3C, "R11 data", d, 8'h3C);
        rd(11'h500, d); chk(d == 8'hFF, "R11 refused word untouched", d, 8'hFF);
    endtask

    task automatic t_mismatch();
        logic [DW-1:0] d;
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'h500, 8'h00);
        chk(ready == 1'b1, "R12 broken unlock", ready, 1);
        rd(11'h500, d); chk(d == 8'hFF, "R12 word unchanged", d, 8'hFF);
        unlock(); wr(11'h555, 8'hF0); wr(11'h500, 8'h00);
        chk(ready == 1'b1, "R12 reset mid sequence", ready, 1);
        unlock(); wr(11'h555, 8'h80); unlock(); wr(11'h555, 8'h30);
        chk(ready == 1'b1, "R12 wrong erase code", ready, 1);
        rd(11'h100, d); chk(d == 8'h34, "R12 array kept", d, 8'h34);
    endtask

    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "R1 ready after reset", ready, 1);
        t_erase();
        t_program();
        t_and();
        t_ignore();
        t_suspend();
        t_ident();
        t_ident_susp();
        t_mismatch();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule